// File: doc/BRIEF.md
# Hot-Plug Slot Event Interrupt and Wake Generator

This block gathers the hot-plug events of one downstream port slot into six sticky status bits and decides how software is told about them. While the port is powered (not in D3hot), an enabled and set status bit raises either a message-signalled interrupt request or a legacy INTx level, depending on the MSI enable and the INTx disable. While the port sits in D3hot, interrupts are held off. Instead, a power-management wake request is raised when an enabled status bit goes from clear to set and PME is enabled.

The status bits are set by one-cycle event pulses and cleared by a write-one-to-clear strobe vector. The per-event enables come from the slot control register, and a single global hot-plug interrupt enable gates interrupts only. Wake generation ignores that global enable. Packet construction and the register bus sit outside this block. The block only presents the status bits and three request outputs.

Top module: `hp_event_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, sts_out is all zero and msi_req, intx_lvl and pme_req are low.
- R2: Status bit index order is 0 attention button, 1 power fault, 2 MRL sensor change, 3 presence change, 4 command completed, 5 data-link state change. An evt_pulse bit seen at a clock edge sets the matching sts_out bit from that edge on. The bit holds until it is cleared, whatever the enables are.
- R3: A one in sts_w1c clears the matching status bit at the clock edge and leaves the other bits unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R4: Outside D3hot, msi_req and intx_lvl stay low unless hp_int_en is 1 and at least one bit of sts_out AND evt_en is 1.
- R5: msi_req is a one-cycle pulse. It is raised in the cycle when the interrupt condition (hp_int_en, not D3hot, masked status non-zero) becomes true while msi_en is 1.
- R6: With msi_en 0 and intx_dis 0, intx_lvl equals the interrupt condition, as a level, in every cycle.
- R7: With msi_en 0 and intx_dis 1, intx_lvl and msi_req both stay low.
- R8: In D3hot with pme_en 1, pme_req pulses for one cycle in the cycle after any enabled status bit goes from clear to set. This happens even when hp_int_en is 0.
- R9: A status bit that is already set and receives another event causes no further pme_req. pme_req stays low outside D3hot, and msi_req and intx_lvl stay low in D3hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | 6 | One-cycle event pulses, one per status bit |
| sts_w1c | input | 6 | Write-one-to-clear strobes for the status bits |
| evt_en | input | 6 | Per-event enables |
| hp_int_en | input | 1 | Global hot-plug interrupt enable |
| msi_en | input | 1 | MSI selected as the interrupt mechanism |
| intx_dis | input | 1 | Legacy INTx disabled |
| pme_en | input | 1 | PME wake enable |
| d3hot | input | 1 | Port is in the D3hot power state |
| sts_out | output | 6 | Sticky event status bits |
| msi_req | output | 1 | MSI request pulse |
| intx_lvl | output | 1 | INTx assertion level |
| pme_req | output | 1 | PME wake request pulse |

## Verification
Random stimulus mixes sparse event pulses, clear strobes and enable changes with both power states. This separates the level-style INTx output from the edge-style MSI and wake outputs, because status bits often stay set across many cycles and enable changes. Directed cases cover several situations:
- an event that collides with a clear of the same bit, which tells event priority apart from clear priority;
- a repeated event on a bit that is already set, which tells transition-based wake apart from level-based wake;
- wake with the global interrupt enable off, which shows that the wake path does not depend on that enable;
- INTx disabled with MSI off, which shows that both interrupt outputs stay quiet.

// File: rtl/hp_evt_pkg.sv
package hp_evt_pkg;
   localparam int HP_NUM_EVT = 6;
   typedef enum int {
      EVT_ATTN    = 0,
      EVT_PWRFLT  = 1,
      EVT_MRL     = 2,
      EVT_PRSNT   = 3,
      EVT_CMDDONE = 4,
      EVT_LINKCHG = 5
   } hp_evt_idx_e;
endpackage

// File: rtl/hp_sts_bit.sv
module hp_sts_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q_o <= 1'b0;
      else if (set_i)
         q_o <= 1'b1;   // an event beats a coincident clear
      else if (clr_i)
         q_o <= 1'b0;
   end
endmodule

// File: rtl/hp_int_sel.sv
module hp_int_sel #(
   parameter int N_EVT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] sts,
   input  logic [N_EVT-1:0] en,
   input  logic             gie,
   input  logic             msi_on,
   input  logic             intx_off,
   input  logic             in_d3,
   output logic             msi_o,
   output logic             intx_o
);
   logic cond;
   logic cond_q;

   assign cond = gie && !in_d3 && ((sts & en) != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond;
   end

   assign msi_o  = msi_on && cond && !cond_q;
   assign intx_o = !msi_on && !intx_off && cond;
endmodule

// File: rtl/hp_wake_det.sv
module hp_wake_det #(
   parameter int N_EVT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] sts,
   input  logic [N_EVT-1:0] en,
   input  logic             pme_on,
   input  logic             in_d3,
   output logic             pme_o
);
   logic [N_EVT-1:0] sts_d;
   logic [N_EVT-1:0] rise;

   always_ff @(posedge clk) begin
      if (!rst_n) sts_d <= '0;
      else        sts_d <= sts;
   end

   assign rise  = sts & ~sts_d & en;
   assign pme_o = pme_on && in_d3 && (rise != '0);
endmodule

// File: rtl/hp_event_gen.sv
module hp_event_gen
   import hp_evt_pkg::*;
#(
   parameter int N_EVT = HP_NUM_EVT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_pulse,
   input  logic [N_EVT-1:0] sts_w1c,
   input  logic [N_EVT-1:0] evt_en,
   input  logic             hp_int_en,
   input  logic             msi_en,
   input  logic             intx_dis,
   input  logic             pme_en,
   input  logic             d3hot,
   output logic [N_EVT-1:0] sts_out,
   output logic             msi_req,
   output logic             intx_lvl,
   output logic             pme_req
);
   localparam int LAST_EVT = N_EVT - 1;

   if (N_EVT < 1 || N_EVT > 32) begin : g_bad_width
      $error("hp_event_gen: N_EVT must be between 1 and 32");
   end
   if (LAST_EVT < int'(EVT_LINKCHG)) begin : g_few_evt
      $error("hp_event_gen: N_EVT too small for the slot event set");
   end

   for (genvar i = 0; i < N_EVT; i++) begin : g_sts
      hp_sts_bit u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (evt_pulse[i]),
         .clr_i (sts_w1c[i]),
         .q_o   (sts_out[i])
      );
   end

   hp_int_sel #(.N_EVT(N_EVT)) u_int (
      .clk      (clk),
      .rst_n    (rst_n),
      .sts      (sts_out),
      .en       (evt_en),
      .gie      (hp_int_en),
      .msi_on   (msi_en),
      .intx_off (intx_dis),
      .in_d3    (d3hot),
      .msi_o    (msi_req),
      .intx_o   (intx_lvl)
   );

   hp_wake_det #(.N_EVT(N_EVT)) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .sts    (sts_out),
      .en     (evt_en),
      .pme_on (pme_en),
      .in_d3  (d3hot),
      .pme_o  (pme_req)
   );
endmodule

// File: rtl/hp_event_chk.sv
module hp_event_chk #(
   parameter int N_EVT = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_EVT-1:0] evt_pulse,
   input logic [N_EVT-1:0] sts_w1c,
   input logic [N_EVT-1:0] evt_en,
   input logic             hp_int_en,
   input logic             msi_en,
   input logic             intx_dis,
   input logic             pme_en,
   input logic             d3hot,
   input logic [N_EVT-1:0] sts_out,
   input logic             msi_req,
   input logic             intx_lvl,
   input logic             pme_req
);
   AST_RST_CLEAR: assert property (@(posedge clk) !rst_n |=> (sts_out == '0) && !msi_req && !intx_lvl && !pme_req); // R1
   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse != '0) |=> ((sts_out & $past(evt_pulse)) == $past(evt_pulse))); // R2
   AST_SET_ONLY_BY_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts_out & ~$past(sts_out) & ~$past(evt_pulse)) == '0)); // R2
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts_w1c & ~evt_pulse) != '0) |=> ((sts_out & $past(sts_w1c & ~evt_pulse)) == '0)); // R3
   AST_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!hp_int_en || ((sts_out & evt_en) == '0)) |-> (!msi_req && !intx_lvl)); // R4
   AST_MSI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      msi_req |=> !msi_req); // R5
   AST_INTX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!msi_en && !intx_dis && !d3hot && hp_int_en && ((sts_out & evt_en) != '0)) |-> intx_lvl); // R6
   AST_INTX_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!msi_en && intx_dis) |-> (!intx_lvl && !msi_req)); // R7
   AST_PME_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      pme_req |-> ((sts_out & ~$past(sts_out) & evt_en) != '0)); // R8
   AST_NO_INT_IN_D3: assert property (@(posedge clk) disable iff (!rst_n)
      d3hot |-> (!msi_req && !intx_lvl)); // R9
   AST_NO_PME_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      !d3hot |-> !pme_req); // R9
endmodule

bind hp_event_gen hp_event_chk #(.N_EVT(N_EVT)) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .sts_w1c(sts_w1c),
   .evt_en(evt_en), .hp_int_en(hp_int_en), .msi_en(msi_en), .intx_dis(intx_dis),
   .pme_en(pme_en), .d3hot(d3hot), .sts_out(sts_out), .msi_req(msi_req),
   .intx_lvl(intx_lvl), .pme_req(pme_req)
);

// File: tb/sim_hp_event_gen.sv
module sim_hp_event_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] evt_pulse = '0, sts_w1c = '0, evt_en = '0;
   logic       hp_int_en = 0, msi_en = 0, intx_dis = 0, pme_en = 0, d3hot = 0;
   logic [5:0] sts_out;
   logic       msi_req, intx_lvl, pme_req;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [5:0] m_sts = '0, m_prev = '0;
   logic       m_condq = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   hp_event_gen u0 (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .sts_w1c(sts_w1c),
      .evt_en(evt_en), .hp_int_en(hp_int_en), .msi_en(msi_en), .intx_dis(intx_dis),
      .pme_en(pme_en), .d3hot(d3hot), .sts_out(sts_out), .msi_req(msi_req),
      .intx_lvl(intx_lvl), .pme_req(pme_req)
   );

   task automatic chk(input string tag, input string what, input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic f_cond(logic [5:0] s, logic [5:0] en, logic gie, logic d3);
      return gie && !d3 && ((s & en) != 6'd0);
   endfunction

   task automatic step(input logic [5:0] e, input logic [5:0] w, input logic [5:0] en,
                       input logic gie, input logic msi, input logic idis,
                       input logic pmee, input logic d3, input string tag);
      logic c;
      @(negedge clk);
      evt_pulse = e; sts_w1c = w; evt_en = en; hp_int_en = gie;
      msi_en = msi; intx_dis = idis; pme_en = pmee; d3hot = d3;
      #1;
      c = f_cond(m_sts, en, gie, d3);
      chk(tag, "sts_out", sts_out, m_sts);
      chk(tag, "msi_req", {5'd0, msi_req}, {5'd0, msi && c && !m_condq});
      chk(tag, "intx_lvl", {5'd0, intx_lvl}, {5'd0, !msi && !idis && c});
      chk(tag, "pme_req", {5'd0, pme_req},
          {5'd0, pmee && d3 && ((m_sts & ~m_prev & en) != 6'd0)});
      m_condq = c;
      m_prev  = m_sts;
      m_sts   = (m_sts & ~w) | e;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int unsigned sd;
      sd = $urandom(32'd2024);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "sts_out in reset", sts_out, 6'd0);
      chk("R1", "outputs in reset", {3'd0, msi_req, intx_lvl, pme_req}, 6'd0);
      rst_n = 1'b1;
      // R1: first cycle after release
      step(6'd0, 6'd0, 6'h3F, 1, 1, 0, 1, 0, "R1");
      // R2: event with enables off still latches and holds
      step(6'b001000, 6'd0, 6'd0, 0, 1, 0, 0, 0, "R2");
      step(6'd0, 6'd0, 6'd0, 0, 1, 0, 0, 0, "R2");
      step(6'd0, 6'd0, 6'd0, 0, 1, 0, 0, 0, "R2");
      // R3: event and clear collide on bit 3; then clear bit 3 only
      step(6'b000001, 6'b001000, 6'd0, 0, 1, 0, 0, 0, "R3");
      step(6'b001000, 6'b001000, 6'd0, 0, 1, 0, 0, 0, "R3");
      step(6'd0, 6'b001000, 6'd0, 0, 1, 0, 0, 0, "R3");
      step(6'd0, 6'd0, 6'd0, 0, 1, 0, 0, 0, "R3");
      // R4: global enable off, all enabled: no interrupts
      step(6'd0, 6'd0, 6'h3F, 0, 1, 0, 0, 0, "R4");
      step(6'd0, 6'd0, 6'h3F, 0, 0, 0, 0, 0, "R4");
      // R5: enabling gie makes condition rise -> one MSI pulse
      step(6'd0, 6'd0, 6'h3F, 1, 1, 0, 0, 0, "R5");
      step(6'd0, 6'd0, 6'h3F, 1, 1, 0, 0, 0, "R5");
      step(6'd0, 6'h3F, 6'h3F, 1, 1, 0, 0, 0, "R5");
      step(6'b100000, 6'd0, 6'h3F, 1, 1, 0, 0, 0, "R5");
      step(6'd0, 6'd0, 6'h3F, 1, 1, 0, 0, 0, "R5");
      // R6: INTx follows condition as level
      step(6'd0, 6'd0, 6'h3F, 1, 0, 0, 0, 0, "R6");
      step(6'd0, 6'd0, 6'h3F, 1, 0, 0, 0, 0, "R6");
      step(6'd0, 6'b100000, 6'h3F, 1, 0, 0, 0, 0, "R6");
      step(6'd0, 6'd0, 6'h3F, 1, 0, 0, 0, 0, "R6");
      // R7: INTx disabled, MSI off
      step(6'b000010, 6'd0, 6'h3F, 1, 0, 1, 0, 0, "R7");
      step(6'd0, 6'd0, 6'h3F, 1, 0, 1, 0, 0, "R7");
      step(6'd0, 6'h3F, 6'h3F, 1, 0, 1, 0, 0, "R7");
      // R8: D3hot wake with gie off
      step(6'b010000, 6'd0, 6'h3F, 0, 1, 0, 1, 1, "R8");
      step(6'd0, 6'd0, 6'h3F, 0, 1, 0, 1, 1, "R8");
      step(6'd0, 6'd0, 6'h3F, 0, 1, 0, 1, 1, "R8");
      // R9: repeat event on set bit -> no wake; no interrupts in D3; no wake awake
      step(6'b010000, 6'd0, 6'h3F, 1, 1, 0, 1, 1, "R9");
      step(6'd0, 6'd0, 6'h3F, 1, 1, 0, 1, 1, "R9");
      step(6'b000100, 6'd0, 6'h3F, 1, 0, 0, 1, 0, "R9");
      step(6'd0, 6'd0, 6'h3F, 1, 0, 0, 1, 0, "R9");
      step(6'd0, 6'h3F, 6'h3F, 1, 0, 0, 1, 0, "R9");
      // constrained random phase
      begin
         logic [5:0] en_r = 6'h3F;
         logic gie_r = 1, msi_r = 1, idis_r = 0, pme_r = 1, d3_r = 0;
         for (int n = 0; n < 3000; n++) begin
            logic [5:0] e_r, w_r;
            e_r = 6'd0; w_r = 6'd0;
            if ($urandom_range(0, 3) == 0) e_r = 6'd1 << $urandom_range(0, 5);
            if ($urandom_range(0, 4) == 0) w_r = 6'($urandom);
            if ($urandom_range(0, 15) == 0) en_r = 6'($urandom);
            if ($urandom_range(0, 15) == 0) gie_r = 1'($urandom);
            if ($urandom_range(0, 20) == 0) msi_r = 1'($urandom);
            if ($urandom_range(0, 20) == 0) idis_r = 1'($urandom);
            if ($urandom_range(0, 20) == 0) pme_r = 1'($urandom);
            if ($urandom_range(0, 25) == 0) d3_r = ~d3_r;
            step(e_r, w_r, en_r, gie_r, msi_r, idis_r, pme_r, d3_r, "R2/R3/R5/R6/R8 random");
         end
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule